// File: doc/BRIEF.md
# Eight-Port I/O Decoder with Shared Interrupt and Status Byte

This block connects a 16-bit I/O address bus to eight serial-port register files. It compares the upper address bits against a ten-position switch setting. When the address lands inside the block's 64-byte window, it raises the chip select of one port and passes the low three address bits on as the register offset. Reads that miss every port return all ones. Write data and the per-port register logic stay outside this block.

Each port reports an interrupt request, and each request is qualified by that port's interrupt-enable output. The enabled requests are registered into a status byte and combined into one shared, level-held interrupt line. When the status-overlay switch is on, offset 7 of every port reads this status byte in place of the port's scratch location. A write to that location leaves the byte unchanged. If any request is still pending, the write forces the shared line low for one clock, so an edge-triggered controller sees a new rising edge.

Top module: `mpio_share_dec`

## Requirements
- R1: The block is hit only when every address bit from 15 down to 6 matches the switch value. A switch bit of 1 (ON) requires a 0 on that address bit, and a switch bit of 0 (OFF) requires a 1. A mismatch in any single bit, including bit 15, is a miss.
- R2: On a hit with `io_rd` or `io_wr` high, `port_cs` is one-hot, with bit n set for addresses base+8n to base+8n+7. `reg_off` equals address bits 2..0. With neither strobe high, `port_cs` is zero.
- R3: On a miss, `port_cs` is zero and `io_rdata` is 0xFF. With no read strobe, `io_rdata` is also 0xFF.
- R4: When `stat_en` is 1, offset 7 of any port is the status location. Reads there return the status byte and no chip select is raised. When `stat_en` is 0, offset 7 is an ordinary port register that raises that port's chip select.
- R5: Status bit n equals `port_req[n] & port_out2[n]` as sampled at the previous clock edge. Bit 0 belongs to the first port and bit 7 to the eighth.
- R6: `irq_out` is 1 one clock after the status byte is non-zero and 0 one clock after it is zero. This applies except in the case of R7.
- R7: A write to the status location leaves the status byte unchanged and raises no chip select. On the first cycle of such a write with a non-zero status, `irq_out` goes to 0 for exactly one clock and then returns to 1. With a zero status, `irq_out` stays 0.
- R8: Synchronous active-high reset clears the status byte and `irq_out`.
- R9: A read of a port register other than the status location returns that port's byte, bits 8n+7..8n of `port_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| base_sw | input | 10 | Base-address switches, 1 = ON (address bit must be 0) |
| stat_en | input | 1 | Status byte overlays offset 7 of every port when 1 |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_rdata | output | 8 | Read data returned to the bus |
| port_cs | output | 8 | One chip select per port |
| reg_off | output | 3 | Register offset within the selected port |
| port_rdata | input | 64 | Read bytes of the eight ports, port n in bits 8n+7..8n |
| port_req | input | 8 | Raw interrupt request per port |
| port_out2 | input | 8 | Interrupt-enable output per port |
| irq_out | output | 1 | Shared interrupt line |

## Verification
The bench targets the polarity of the switch compare and partial decoding. It uses two base settings and an address that differs from the base only in bit 15. A decoder that ignored the top bit or inverted the switch sense would select a port there. It also checks that the overlay switch alone decides whether offset 7 is the status byte or a port register. The retrigger case measures the exact cycle when `irq_out` drops and returns after a status write. A design without the one-clock gap would never produce a fresh edge. A design that cleared the status on the write would lose the pending bits on the next read. A write with zero status must not create a spurious pulse. Requests with the enable output low must never reach the status byte or the line.

// File: rtl/mpio_pkg.sv
package mpio_pkg;

    localparam int unsigned MP_ADDR_W = 16;
    localparam int unsigned MP_DATA_W = 8;
    localparam int unsigned MP_NPORTS = 8;
    localparam int unsigned MP_REG_W  = 3;

    // Kind of bus cycle seen in the current clock
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    // Read takes precedence if both strobes are high
    function automatic acc_e acc_kind(input logic rd, input logic wr);
        if (rd)      return ACC_READ;
        else if (wr) return ACC_WRITE;
        else         return ACC_NONE;
    endfunction

    // Switch ON (1) demands address bit 0; OFF (0) demands address bit 1
    function automatic logic sw_bit_ok(input logic a, input logic sw);
        return a ^ sw;
    endfunction

endpackage

// File: rtl/mpio_addr_dec.sv
module mpio_addr_dec
    import mpio_pkg::*;
#(
    parameter int unsigned ADDR_W = MP_ADDR_W,
    parameter int unsigned NPORTS = MP_NPORTS,
    parameter int unsigned REG_W  = MP_REG_W,
    localparam int unsigned PSEL_W = $clog2(NPORTS),
    localparam int unsigned BLK_W  = PSEL_W + REG_W,
    localparam int unsigned SW_W   = ADDR_W - BLK_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SW_W-1:0]   base_sw,
    input  logic              stat_en,
    input  logic              rd,
    input  logic              wr,
    output logic [NPORTS-1:0] cs,
    output logic [PSEL_W-1:0] port_idx,
    output logic [REG_W-1:0]  reg_idx,
    output logic              port_rd,
    output logic              stat_rd,
    output logic              stat_wr
);

    logic [SW_W-1:0] bit_ok;
    logic            blk_hit;
    logic            stat_loc;
    acc_e            acc;

    // Per-bit compare of the upper address against the switches
    for (genvar b = 0; b < SW_W; b++) begin : g_cmp
        assign bit_ok[b] = sw_bit_ok(addr[BLK_W + b], base_sw[b]);
    end

    assign blk_hit  = &bit_ok;
    assign port_idx = addr[BLK_W-1:REG_W];
    assign reg_idx  = addr[REG_W-1:0];
    assign stat_loc = stat_en && (reg_idx == {REG_W{1'b1}});
    assign acc      = acc_kind(rd, wr);

    for (genvar g = 0; g < NPORTS; g++) begin : g_cs
        assign cs[g] = blk_hit && (acc != ACC_NONE) && !stat_loc
                       && (port_idx == PSEL_W'(g));
    end

    assign port_rd = blk_hit && (acc == ACC_READ)  && !stat_loc;
    assign stat_rd = blk_hit && (acc == ACC_READ)  &&  stat_loc;
    assign stat_wr = blk_hit && (acc == ACC_WRITE) &&  stat_loc;

endmodule

// File: rtl/mpio_irq_share.sv
module mpio_irq_share #(
    parameter int unsigned NPORTS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPORTS-1:0] port_req,
    input  logic [NPORTS-1:0] port_out2,
    input  logic              stat_wr,
    output logic [NPORTS-1:0] pend_q,
    output logic              irq_q
);

    logic wr_prev_q;
    logic kick;

    // Only the first cycle of a status write re-arms the line
    assign kick = stat_wr && !wr_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            wr_prev_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            pend_q    <= port_req & port_out2;
            wr_prev_q <= stat_wr;
            irq_q     <= (|pend_q) && !kick;
        end
    end

endmodule

// File: rtl/mpio_rd_mux.sv
module mpio_rd_mux #(
    parameter int unsigned NPORTS = 8,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned PSEL_W = $clog2(NPORTS)
) (
    input  logic [NPORTS*DATA_W-1:0] port_rdata,
    input  logic [PSEL_W-1:0]        port_idx,
    input  logic                     port_rd,
    input  logic                     stat_rd,
    input  logic [NPORTS-1:0]        pend,
    output logic [DATA_W-1:0]        rdata
);

    logic [DATA_W-1:0] masked [NPORTS];
    logic [DATA_W-1:0] port_word;
    logic [DATA_W-1:0] stat_word;

    for (genvar g = 0; g < NPORTS; g++) begin : g_sel
        assign masked[g] = (port_idx == PSEL_W'(g))
                           ? port_rdata[g*DATA_W +: DATA_W] : '0;
    end

    always_comb begin
        port_word = '0;
        for (int i = 0; i < NPORTS; i++) port_word |= masked[i];
        stat_word = '0;
        stat_word[NPORTS-1:0] = pend;
    end

    always_comb begin
        if (stat_rd)      rdata = stat_word;
        else if (port_rd) rdata = port_word;
        else              rdata = '1;
    end

endmodule

// File: rtl/mpio_share_dec.sv
module mpio_share_dec
    import mpio_pkg::*;
#(
    parameter int unsigned ADDR_W = MP_ADDR_W,
    parameter int unsigned DATA_W = MP_DATA_W,
    parameter int unsigned NPORTS = MP_NPORTS,
    parameter int unsigned REG_W  = MP_REG_W,
    localparam int unsigned PSEL_W = $clog2(NPORTS),
    localparam int unsigned SW_W   = ADDR_W - PSEL_W - REG_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SW_W-1:0]          base_sw,
    input  logic                     stat_en,
    input  logic [ADDR_W-1:0]        io_addr,
    input  logic                     io_rd,
    input  logic                     io_wr,
    output logic [DATA_W-1:0]        io_rdata,
    output logic [NPORTS-1:0]        port_cs,
    output logic [REG_W-1:0]         reg_off,
    input  logic [NPORTS*DATA_W-1:0] port_rdata,
    input  logic [NPORTS-1:0]        port_req,
    input  logic [NPORTS-1:0]        port_out2,
    output logic                     irq_out
);

    logic [PSEL_W-1:0] port_idx;
    logic              port_rd;
    logic              stat_rd;
    logic              stat_wr;
    logic [NPORTS-1:0] pend_q;

    mpio_addr_dec #(
        .ADDR_W(ADDR_W), .NPORTS(NPORTS), .REG_W(REG_W)
    ) u_dec (
        .addr    (io_addr),
        .base_sw (base_sw),
        .stat_en (stat_en),
        .rd      (io_rd),
        .wr      (io_wr),
        .cs      (port_cs),
        .port_idx(port_idx),
        .reg_idx (reg_off),
        .port_rd (port_rd),
        .stat_rd (stat_rd),
        .stat_wr (stat_wr)
    );

    mpio_irq_share #(.NPORTS(NPORTS)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .port_req (port_req),
        .port_out2(port_out2),
        .stat_wr  (stat_wr),
        .pend_q   (pend_q),
        .irq_q    (irq_out)
    );

    mpio_rd_mux #(.NPORTS(NPORTS), .DATA_W(DATA_W)) u_mux (
        .port_rdata(port_rdata),
        .port_idx  (port_idx),
        .port_rd   (port_rd),
        .stat_rd   (stat_rd),
        .pend      (pend_q),
        .rdata     (io_rdata)
    );

endmodule

// File: rtl/mpio_share_dec_chk.sv
module mpio_share_dec_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NPORTS = 8,
    parameter int unsigned REG_W  = 3,
    localparam int unsigned PSEL_W = $clog2(NPORTS),
    localparam int unsigned BLK_W  = PSEL_W + REG_W,
    localparam int unsigned SW_W   = ADDR_W - BLK_W
) (
    input logic              clk,
    input logic              rst,
    input logic [SW_W-1:0]   base_sw,
    input logic              stat_en,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [DATA_W-1:0] io_rdata,
    input logic [NPORTS-1:0] port_cs,
    input logic [NPORTS-1:0] port_req,
    input logic [NPORTS-1:0] port_out2,
    input logic [NPORTS-1:0] pend_q,
    input logic              irq_out
);

    logic              hit;
    logic              at_stat;
    logic              wr_stat;
    logic [DATA_W-1:0] pend_w;

    always_comb begin
        hit     = (io_addr[ADDR_W-1:BLK_W] == ~base_sw);
        at_stat = hit && stat_en && (io_addr[REG_W-1:0] == {REG_W{1'b1}});
        wr_stat = at_stat && io_wr && !io_rd;
        pend_w  = '0;
        pend_w[NPORTS-1:0] = pend_q;
    end

    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(port_cs));

    // R3
    miss_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (port_cs == '0 && io_rdata == {DATA_W{1'b1}}));

    // R4
    stat_read_chk: assert property (@(posedge clk) disable iff (rst)
        (at_stat && io_rd) |-> (io_rdata == pend_w && port_cs == '0));

    // R5
    pend_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (pend_q == $past(port_req & port_out2)));

    // R6
    irq_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q == '0) |=> !irq_out);

    // R6
    irq_high_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q != '0 && !(wr_stat && !$past(wr_stat))) |=> irq_out);

    // R7
    kick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !$past(wr_stat)) |=> !irq_out);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pend_q == '0 && !irq_out));

endmodule

bind mpio_share_dec mpio_share_dec_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPORTS(NPORTS), .REG_W(REG_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .base_sw  (base_sw),
    .stat_en  (stat_en),
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_rdata (io_rdata),
    .port_cs  (port_cs),
    .port_req (port_req),
    .port_out2(port_out2),
    .pend_q   (pend_q),
    .irq_out  (irq_out)
);

// File: tb/mpio_share_dec_test.sv
module mpio_share_dec_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  base_sw = 10'h3F3;
    logic        stat_en = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_rdata;
    logic [7:0]  port_cs;
    logic [2:0]  reg_off;
    logic [63:0] port_rdata;
    logic [7:0]  port_req = 8'h00;
    logic [7:0]  port_out2 = 8'hFF;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int n = 0; n < 8; n++) port_rdata[n*8 +: 8] = 8'h30 + 8'(n);
    end

    mpio_share_dec uut (
        .clk(clk), .rst(rst), .base_sw(base_sw), .stat_en(stat_en),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
        .port_cs(port_cs), .reg_off(reg_off), .port_rdata(port_rdata),
        .port_req(port_req), .port_out2(port_out2), .irq_out(irq_out)
    );

    function automatic logic [15:0] base_of(input logic [9:0] sw);
        return {~sw, 6'b000000};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        port_req = 8'hFF; port_out2 = 8'hFF; stat_en = 1'b1;
        repeat (3) @(negedge clk);
        io_addr = base_of(base_sw) + 16'd7; io_rd = 1'b1;
        #1;
        check("R8 irq in reset", {15'd0, irq_out}, 16'd0);
        check("R8 status in reset", {8'd0, io_rdata}, 16'h0000);
        io_rd = 1'b0; port_req = 8'h00; stat_en = 1'b0;
        rst = 1'b0;
        idle();
    endtask

    task automatic t_port_select();
        for (int n = 0; n < 8; n++) begin
            do_read(base_of(base_sw) + 16'(8*n + 3));
            check("R2 cs per port", {8'd0, port_cs}, 16'(1 << n));
            check("R2 reg_off", {13'd0, reg_off}, 16'd3);
            check("R9 port data", {8'd0, io_rdata}, 16'h30 + 16'(n));
        end
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b1; io_addr = base_of(base_sw) + 16'd21;
        #1;
        check("R2 write cs", {8'd0, port_cs}, 16'h0004);
        io_wr = 1'b0;
        #1;
        check("R2 no strobe", {8'd0, port_cs}, 16'h0000);
        check("R3 no strobe data", {8'd0, io_rdata}, 16'h00FF);
    endtask

    task automatic t_other_base();
        base_sw = 10'h294;
        do_read(16'h5AC0 + 16'd42);
        check("R1 base 5AC0 port5", {8'd0, port_cs}, 16'h0020);
        check("R9 base 5AC0 data", {8'd0, io_rdata}, 16'h0035);
        do_read(16'h5AC0 + 16'd64);
        check("R3 past window cs", {8'd0, port_cs}, 16'h0000);
        check("R3 past window data", {8'd0, io_rdata}, 16'h00FF);
        do_read(16'hDAC0);
        check("R1 bit15 alias", {8'd0, port_cs}, 16'h0000);
        do_read(16'h0300);
        check("R1 old base", {8'd0, io_rdata}, 16'h00FF);
        idle();
        base_sw = 10'h3F3;
    endtask

    task automatic t_scratch_mode();
        stat_en = 1'b0;
        do_read(base_of(base_sw) + 16'd15);
        check("R4 scratch cs", {8'd0, port_cs}, 16'h0002);
        check("R4 scratch data", {8'd0, io_rdata}, 16'h0031);
        idle();
    endtask

    task automatic t_status_overlay();
        stat_en = 1'b1;
        port_out2 = 8'hFF; port_req = 8'h85;
        @(negedge clk);
        do_read(base_of(base_sw) + 16'd31);
        check("R4 status cs", {8'd0, port_cs}, 16'h0000);
        check("R5 status bits", {8'd0, io_rdata}, 16'h0085);
        idle();
    endtask

    task automatic t_out2_gate();
        port_req = 8'hFF; port_out2 = 8'h0F;
        @(negedge clk);
        do_read(base_of(base_sw) + 16'd7);
        check("R5 gated status", {8'd0, io_rdata}, 16'h000F);
        io_rd = 1'b0;
        port_out2 = 8'h00;
        repeat (2) @(negedge clk);
        #1;
        check("R5 all gated irq", {15'd0, irq_out}, 16'd0);
        port_req = 8'h00; port_out2 = 8'hFF;
        idle();
    endtask

    task automatic t_irq_level();
        repeat (2) @(negedge clk);
        port_req = 8'h10;
        @(negedge clk);
        check("R6 irq latency 1", {15'd0, irq_out}, 16'd0);
        @(negedge clk);
        check("R6 irq asserted", {15'd0, irq_out}, 16'd1);
        port_req = 8'h00;
        @(negedge clk);
        check("R6 irq hold", {15'd0, irq_out}, 16'd1);
        @(negedge clk);
        check("R6 irq released", {15'd0, irq_out}, 16'd0);
    endtask

    task automatic t_retrigger();
        stat_en = 1'b1; port_req = 8'h41;
        repeat (3) @(negedge clk);
        check("R7 pre irq", {15'd0, irq_out}, 16'd1);
        io_addr = base_of(base_sw) + 16'd55; io_wr = 1'b1;
        #1;
        check("R7 write no cs", {8'd0, port_cs}, 16'h0000);
        @(negedge clk);
        check("R7 gap", {15'd0, irq_out}, 16'd0);
        io_wr = 1'b0;
        @(negedge clk);
        check("R7 re-asserted", {15'd0, irq_out}, 16'd1);
        do_read(base_of(base_sw) + 16'd7);
        check("R7 status kept", {8'd0, io_rdata}, 16'h0041);
        idle();
        port_req = 8'h00;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_write_zero();
        stat_en = 1'b1;
        io_addr = base_of(base_sw) + 16'd7; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        check("R7 zero write no irq", {15'd0, irq_out}, 16'd0);
        @(negedge clk);
        check("R7 zero write still low", {15'd0, irq_out}, 16'd0);
    endtask

    task automatic t_scratch_write();
        stat_en = 1'b0; port_req = 8'h02;
        repeat (3) @(negedge clk);
        io_addr = base_of(base_sw) + 16'd15; io_wr = 1'b1;
        #1;
        check("R4 scratch write cs", {8'd0, port_cs}, 16'h0002);
        @(negedge clk);
        io_wr = 1'b0;
        check("R4 scratch write no gap", {15'd0, irq_out}, 16'd1);
        port_req = 8'h00;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_port_select();
        t_other_base();
        t_scratch_mode();
        t_status_overlay();
        t_out2_gate();
        t_irq_level();
        t_retrigger();
        t_write_zero();
        t_scratch_write();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule